// File: doc/BRIEF.md
# I2C Byte Master Engine

This block is the master half of a byte-at-a-time I2C controller. Software sets request bits (start, stop) and clears an event flag through single-cycle pulses. The engine turns these into bus conditions and byte transfers on open-drain SDA and SCL. Each line is modelled as a drive-low enable plus a sampled input. After each bus event the engine raises the event flag. While the flag is up and the engine owns the bus, it holds SCL low, so the transfer is paced by software.

Bytes enter on a valid/ready command stream that carries a direction bit and a write byte. A received byte leaves on a valid/ready stream. Back-pressure rules:
- A command is taken only on a cycle where `tx_valid` and `tx_ready` are both high.
- `tx_ready` stays low while a received byte is still waiting for `rx_ready`.
- `rx_valid` and `rx_data` hold until `rx_ready` is seen.

SCL timing comes from a programmable divider. Loss of arbitration is detected as an SDA mismatch and reported on a status pin.

Top module: `i2c_byte_master`

## Requirements
- R1: While `ctl_en` is 0, one clock later `scl_oe` and `sda_oe` are 0, and `evt_flag`, `is_master`, `arb_lost`, `bus_busy` and both pending requests are 0.
- R2: A start request made while not master waits as long as `bus_busy` is 1. It then pulls SDA low with SCL released, then pulls SCL low, then sets `evt_flag` and `is_master` and clears `start_pending`.
- R3: A start request made while master, with the flag cleared, produces a repeated START: SDA is released with SCL low, SCL is released, and SDA falls with SCL high. `evt_flag` is then set and `is_master` stays 1; no STOP appears on the bus.
- R4: A stop request made while master produces a STOP (SDA rises while SCL is high). `stop_pending` is cleared, `is_master` drops, and both lines are released without raising `evt_flag`. A stop request made while not master is dropped with no bus activity.
- R5: Once set, `evt_flag` stays 1 until `flag_clr` is pulsed. While it is 1 and the engine is master, `scl_oe` stays 1 and no command is taken.
- R6: A write command sends the byte MSB first over 8 SCL pulses. A ninth pulse follows with SDA released. `ack_seen` becomes 1 if SDA was low on that pulse, and `evt_flag` is set after it.
- R7: A read command releases SDA for 8 pulses and assembles the byte MSB first into `rx_data`, with `rx_valid` = 1 and `evt_flag` set. On the ninth pulse SDA is pulled low only if `ctl_ack_en` is 1.
- R8: `tx_ready` is 1 only when the engine is master, its flag is clear, no start or stop request is pending and `rx_valid` is 0. `rx_valid` and `rx_data` are held until `rx_ready`.
- R9: If the engine releases SDA during a write bit but samples it low, `arb_lost` goes to 1 and the engine stops pulling SDA. It still completes all 9 SCL pulses, then sets `evt_flag`, clears `is_master` and releases SCL.
- R10: Each generated SCL half-period lasts `BASE_HALF << ctl_rate` clocks (default `BASE_HALF` = 4).
- R11: `bus_busy` is set by a START on the lines (SDA falls with SCL high) and cleared by a STOP (SDA rises with SCL high), whoever drives them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Interface enable; 0 holds it in reset |
| ctl_rate | input | 3 | SCL half-period select |
| ctl_ack_en | input | 1 | Acknowledge received bytes when 1 |
| start_set | input | 1 | Pulse: request START |
| stop_set | input | 1 | Pulse: request STOP |
| flag_clr | input | 1 | Pulse: clear the event flag |
| tx_valid | input | 1 | Byte command valid |
| tx_ready | output | 1 | Byte command accepted this cycle when valid |
| tx_read | input | 1 | Command direction: 1 reads, 0 writes |
| tx_data | input | 8 | Byte to write |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| evt_flag | output | 1 | Event flag |
| is_master | output | 1 | Engine owns the bus |
| arb_lost | output | 1 | Arbitration lost during last write |
| ack_seen | output | 1 | Slave acknowledged the last written byte |
| start_pending | output | 1 | START request outstanding |
| stop_pending | output | 1 | STOP request outstanding |
| bus_busy | output | 1 | A START has been seen without a later STOP |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The bench sends a start request while another master holds the bus. An engine that ignored `bus_busy` would drive a START onto the active bus. It watches the clock after an arbitration loss: a design that quits early shows fewer than nine SCL rises, and one that keeps holding SCL or stays master blocks the bus. It holds `tx_valid` high during a raised flag and while a read byte is still unread; a design with a loose handshake would start a byte there. The bench also checks that the acknowledge follows `ctl_ack_en`, that a STOP on the lines clears the stop request, and the measured SCL high time at two rate settings.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ST_A, S_ST_B, S_HOLD,
    S_RS_A, S_RS_B, S_SP_A, S_SP_B, S_SP_C,
    S_BIT_L, S_BIT_H
  } seq_state_e;

  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned RATE_W    = 3;
endpackage

// File: rtl/i2cm_rate_div.sv
module i2cm_rate_div #(
  parameter int unsigned BASE_HALF = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          run,
  input  logic [i2cm_pkg::RATE_W-1:0]   rate,
  output logic                          tick
);
  localparam int unsigned MAX_HALF = BASE_HALF << ((1 << i2cm_pkg::RATE_W) - 1);
  localparam int unsigned CW       = $clog2(MAX_HALF + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] half;

  assign half = CW'(BASE_HALF) << rate;
  assign tick = run && (cnt == half - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || !run) cnt <= '0;
    else if (tick)       cnt <= '0;
    else                 cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/i2cm_bus_mon.sv
module i2cm_bus_mon #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic stop_det,
  output logic busy
);
  logic scl_s;
  logic scl_d, sda_d;
  logic start_det;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign scl_s = scl_i;
      assign sda_s = sda_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] scl_q, sda_q;
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_q[i] <= 1'b1;
            sda_q[i] <= 1'b1;
          end else if (!en) begin
            scl_q[i] <= 1'b1;
            sda_q[i] <= 1'b1;
          end else if (i == 0) begin
            scl_q[i] <= scl_i;
            sda_q[i] <= sda_i;
          end else begin
            scl_q[i] <= scl_q[(i > 0) ? i - 1 : 0];
            sda_q[i] <= sda_q[(i > 0) ? i - 1 : 0];
          end
        end
      end
      assign scl_s = scl_q[SYNC_STAGES-1];
      assign sda_s = sda_q[SYNC_STAGES-1];
    end
  endgenerate

  assign start_det = scl_d && scl_s && sda_d && !sda_s;
  assign stop_det  = scl_d && scl_s && !sda_d && sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      busy  <= 1'b0;
    end else if (!en) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 ack_en,
  input  logic                 start_set,
  input  logic                 stop_set,
  input  logic                 flag_clr,
  input  logic                 tick,
  input  logic                 sda_s,
  input  logic                 busy,
  input  logic                 stop_det,
  input  logic                 tx_valid,
  input  logic                 tx_read,
  input  logic [BYTE_BITS-1:0] tx_data,
  input  logic                 rx_ready,
  output logic                 timed,
  output logic                 tx_ready,
  output logic                 rx_valid,
  output logic [BYTE_BITS-1:0] rx_data,
  output logic                 flag,
  output logic                 master,
  output logic                 arb_lost,
  output logic                 ack_seen,
  output logic                 start_req,
  output logic                 stop_req,
  output logic                 scl_oe,
  output logic                 sda_oe
);
  localparam int unsigned CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_BITS);

  seq_state_e           st;
  logic [BYTE_BITS-1:0] shreg;
  logic [CNT_W-1:0]     bcnt;
  logic                 rd;
  logic                 lost_now;

  assign timed    = (st != S_IDLE) && (st != S_HOLD);
  assign tx_ready = (st == S_HOLD) && master && !flag && !start_req && !stop_req && !rx_valid;
  assign lost_now = !rd && !arb_lost && shreg[BYTE_BITS-1] && !sda_s && (bcnt != ACK_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en) begin
      st        <= S_IDLE;
      shreg     <= '0;
      bcnt      <= '0;
      rd        <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      flag      <= 1'b0;
      master    <= 1'b0;
      arb_lost  <= 1'b0;
      ack_seen  <= 1'b0;
      start_req <= 1'b0;
      stop_req  <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      if (start_set)           start_req <= 1'b1;
      if (stop_set)            stop_req  <= 1'b1;
      if (stop_det)            stop_req  <= 1'b0;
      if (flag_clr)            flag      <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;

      unique case (st)
        S_IDLE: begin
          scl_oe   <= 1'b0;
          sda_oe   <= 1'b0;
          stop_req <= 1'b0;
          if (start_req && !busy && !flag) begin
            st       <= S_ST_A;
            sda_oe   <= 1'b1;
            arb_lost <= 1'b0;
          end
        end
        S_ST_A: if (tick) begin
          st     <= S_ST_B;
          scl_oe <= 1'b1;
        end
        S_ST_B: if (tick) begin
          st        <= S_HOLD;
          flag      <= 1'b1;
          master    <= 1'b1;
          start_req <= 1'b0;
        end
        S_HOLD: begin
          if (!flag) begin
            if (start_req) begin
              st     <= S_RS_A;
              sda_oe <= 1'b0;
            end else if (stop_req) begin
              st     <= S_SP_A;
              sda_oe <= 1'b1;
            end else if (tx_valid && tx_ready) begin
              st     <= S_BIT_L;
              shreg  <= tx_data;
              rd     <= tx_read;
              bcnt   <= '0;
              sda_oe <= !tx_read && !tx_data[BYTE_BITS-1];
            end
          end
        end
        S_RS_A: if (tick) begin
          st     <= S_RS_B;
          scl_oe <= 1'b0;
        end
        S_RS_B: if (tick) begin
          st     <= S_ST_A;
          sda_oe <= 1'b1;
        end
        S_SP_A: if (tick) begin
          st     <= S_SP_B;
          scl_oe <= 1'b0;
        end
        S_SP_B: if (tick) begin
          st     <= S_SP_C;
          sda_oe <= 1'b0;
        end
        S_SP_C: if (tick) begin
          st     <= S_IDLE;
          master <= 1'b0;
        end
        S_BIT_L: if (tick) begin
          st     <= S_BIT_H;
          scl_oe <= 1'b0;
        end
        S_BIT_H: if (tick) begin
          if (bcnt == ACK_SLOT) begin
            if (rd) begin
              rx_data  <= shreg;
              rx_valid <= 1'b1;
            end else begin
              ack_seen <= !sda_s;
            end
            flag <= 1'b1;
            if (arb_lost) begin
              st     <= S_IDLE;
              master <= 1'b0;
              scl_oe <= 1'b0;
              sda_oe <= 1'b0;
            end else begin
              st     <= S_HOLD;
              scl_oe <= 1'b1;
            end
          end else begin
            shreg  <= {shreg[BYTE_BITS-2:0], sda_s};
            bcnt   <= bcnt + CNT_W'(1);
            st     <= S_BIT_L;
            scl_oe <= 1'b1;
            if (lost_now) arb_lost <= 1'b1;
            if (bcnt == LAST_DATA)
              sda_oe <= rd && ack_en;
            else
              sda_oe <= !rd && !arb_lost && !lost_now && !shreg[BYTE_BITS-2];
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int unsigned BASE_HALF   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_en,
  input  logic [2:0] ctl_rate,
  input  logic       ctl_ack_en,
  input  logic       start_set,
  input  logic       stop_set,
  input  logic       flag_clr,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic       tx_read,
  input  logic [7:0] tx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       evt_flag,
  output logic       is_master,
  output logic       arb_lost,
  output logic       ack_seen,
  output logic       start_pending,
  output logic       stop_pending,
  output logic       bus_busy,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic tick, timed, sda_s, stop_det;

  i2cm_rate_div #(.BASE_HALF(BASE_HALF)) div_i (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .run(timed), .rate(ctl_rate), .tick(tick)
  );

  i2cm_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) mon_i (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .stop_det(stop_det), .busy(bus_busy)
  );

  i2cm_seq seq_i (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .ack_en(ctl_ack_en),
    .start_set(start_set), .stop_set(stop_set), .flag_clr(flag_clr),
    .tick(tick), .sda_s(sda_s), .busy(bus_busy), .stop_det(stop_det),
    .tx_valid(tx_valid), .tx_read(tx_read), .tx_data(tx_data), .rx_ready(rx_ready),
    .timed(timed), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .flag(evt_flag), .master(is_master), .arb_lost(arb_lost), .ack_seen(ack_seen),
    .start_req(start_pending), .stop_req(stop_pending),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_en,
  input logic       flag_clr,
  input logic       evt_flag,
  input logic       is_master,
  input logic       arb_lost,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       scl_oe,
  input logic       sda_oe
);
  p_disable_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> (!scl_oe && !sda_oe && !evt_flag && !is_master));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !flag_clr && ctl_en) |=> evt_flag);

  p_flag_holds_scl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && is_master) |-> scl_oe);

  p_no_accept_on_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag || rx_valid) |-> !tx_ready);

  p_rx_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && ctl_en) |=> (rx_valid && $stable(rx_data)));

  p_lost_frees_sda_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !sda_oe);
endmodule

bind i2c_byte_master i2cm_checker chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .flag_clr(flag_clr),
  .evt_flag(evt_flag), .is_master(is_master), .arb_lost(arb_lost),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       ctl_en = 1'b1;
  logic [2:0] ctl_rate = 3'd0;
  logic       ctl_ack_en = 1'b1;
  logic       start_set = 1'b0, stop_set = 1'b0, flag_clr = 1'b0;
  logic       tx_valid = 1'b0, tx_read = 1'b0, rx_ready = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, rx_valid, evt_flag, is_master, arb_lost, ack_seen;
  logic       start_pending, stop_pending, bus_busy, scl_oe, sda_oe;
  logic [7:0] rx_data;

  logic       ext_sda = 1'b0, ext_scl = 1'b0;
  logic [8:0] slv_pat = 9'd0;
  logic [3:0] slv_idx = 4'd9;
  logic       slv_pull, scl_line, sda_line;

  assign slv_pull = (slv_idx < 4'd9) ? slv_pat[slv_idx] : 1'b0;
  assign scl_line = !(scl_oe || ext_scl);
  assign sda_line = !(sda_oe || slv_pull || ext_sda);

  i2c_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_rate(ctl_rate), .ctl_ack_en(ctl_ack_en),
    .start_set(start_set), .stop_set(stop_set), .flag_clr(flag_clr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_read(tx_read), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .evt_flag(evt_flag), .is_master(is_master), .arb_lost(arb_lost), .ack_seen(ack_seen),
    .start_pending(start_pending), .stop_pending(stop_pending), .bus_busy(bus_busy),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // bus observer
  logic       scl_p = 1'b1, sda_p = 1'b1;
  int         n_start = 0, n_stop = 0, hi_run = 0, last_hi = 0, rises = 0;
  logic [8:0] cap = 9'd0;

  always @(posedge clk) begin
    scl_p <= scl_line;
    sda_p <= sda_line;
    if (scl_p && scl_line && sda_p && !sda_line) n_start <= n_start + 1;
    if (scl_p && scl_line && !sda_p && sda_line) n_stop  <= n_stop + 1;
    if (scl_line) hi_run <= hi_run + 1;
    else begin
      if (hi_run != 0) last_hi <= hi_run;
      hi_run <= 0;
    end
    if (tx_valid && tx_ready) begin
      cap <= 9'd0; rises <= 0; slv_idx <= 4'd0;
    end else begin
      if (scl_line && !scl_p) begin
        cap   <= {cap[7:0], sda_line};
        rises <= rises + 1;
      end
      if (!scl_line && scl_p && slv_idx < 4'd9) slv_idx <= slv_idx + 4'd1;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic wait_flag(input int lim, input string req);
    int n = 0;
    while (!evt_flag && n < lim) begin @(negedge clk); n++; end
    chk(evt_flag, req, {31'd0, evt_flag}, 32'd1);
  endtask

  task automatic issue(input bit rd, input logic [7:0] d, input string req);
    int n = 0;
    tx_read = rd; tx_data = d; tx_valid = 1'b1;
    while (!tx_ready && n < 500) begin @(negedge clk); n++; end
    chk(tx_ready, req, {31'd0, tx_ready}, 32'd1);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // {rd, ack_en, slave_ack, data}
  localparam logic [10:0] VECS [0:5] = '{
    {1'b0, 1'b1, 1'b1, 8'hA5},
    {1'b0, 1'b1, 1'b0, 8'h3C},
    {1'b0, 1'b0, 1'b1, 8'h00},
    {1'b1, 1'b1, 1'b0, 8'h5A},
    {1'b1, 1'b0, 1'b0, 8'hC3},
    {1'b0, 1'b1, 1'b1, 8'hFF}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int s0, p0, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state, R1
    chk(!scl_oe && !sda_oe && !evt_flag && !is_master && !bus_busy && !tx_ready, "R1 reset",
        {26'd0, scl_oe, sda_oe, evt_flag, is_master, bus_busy, tx_ready}, 32'd0);

    // START from idle: R2, R11
    s0 = n_start;
    pulse(start_set);
    wait_flag(200, "R2 start flag");
    chk(is_master && !start_pending && scl_oe && sda_oe, "R2 master after start",
        {28'd0, is_master, start_pending, scl_oe, sda_oe}, 32'hB);
    chk(n_start == s0 + 1, "R2 start on bus", n_start, s0 + 1);
    @(negedge clk); @(negedge clk);
    chk(bus_busy, "R11 busy after start", {31'd0, bus_busy}, 32'd1);

    // stall while flag set: R5
    bad = 0;
    tx_valid = 1'b1; tx_data = 8'h11; tx_read = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (tx_ready || !scl_oe || !evt_flag) bad++;
    end
    tx_valid = 1'b0;
    chk(bad == 0, "R5 stall while flag", bad, 0);
    pulse(flag_clr);
    chk(!evt_flag, "R5 flag cleared", {31'd0, evt_flag}, 32'd0);

    // vector table: R6 R7 R8
    for (int v = 0; v < 6; v++) begin
      logic rd, ae, sa;
      logic [7:0] d;
      {rd, ae, sa, d} = VECS[v];
      ctl_ack_en = ae;
      if (rd) for (int b = 0; b < 8; b++) slv_pat[b] = !d[7-b];
      else    slv_pat[7:0] = 8'd0;
      slv_pat[8] = rd ? 1'b0 : sa;
      chk(tx_ready, "R8 ready when idle master", {31'd0, tx_ready}, 32'd1);
      issue(rd, d, "R8 accept");
      wait_flag(500, rd ? "R7 flag" : "R6 flag");
      chk(rises == 9, rd ? "R7 nine clocks" : "R6 nine clocks", rises, 9);
      chk(cap[8:1] == d, rd ? "R7 bus bits" : "R6 bus bits", cap[8:1], d);
      if (rd) begin
        chk(rx_valid && rx_data == d, "R7 rx byte", {23'd0, rx_valid, rx_data}, {23'd0, 1'b1, d});
        chk(cap[0] == !ae, "R7 ack slot", cap[0], !ae);
        pulse(flag_clr);
        repeat (5) @(negedge clk);
        chk(rx_valid && !tx_ready, "R8 rx held blocks tx", {30'd0, rx_valid, tx_ready}, 32'd2);
        pulse(rx_ready);
        chk(!rx_valid && tx_ready, "R8 rx consumed", {30'd0, rx_valid, tx_ready}, 32'd1);
      end else begin
        chk(ack_seen == sa && cap[0] == !sa, "R6 ack seen", {30'd0, ack_seen, cap[0]}, {30'd0, sa, !sa});
        pulse(flag_clr);
      end
      chk(!arb_lost && is_master, "R6 no loss", {30'd0, arb_lost, is_master}, 32'd1);
    end
    slv_pat = 9'd0;
    chk(last_hi == 4, "R10 rate 0 high time", last_hi, 4);

    // rate 2: R10
    ctl_rate = 3'd2;
    issue(1'b0, 8'h00, "R10 accept");
    wait_flag(2000, "R10 flag");
    repeat (2) @(negedge clk);
    chk(last_hi == 16, "R10 rate 2 high time", last_hi, 16);
    ctl_rate = 3'd0;
    pulse(flag_clr);

    // repeated START: R3
    s0 = n_start; p0 = n_stop;
    pulse(start_set);
    wait_flag(300, "R3 flag");
    chk(is_master && n_start == s0 + 1 && n_stop == p0, "R3 repeated start",
        n_start - s0 + 16 * (n_stop - p0), 1);
    pulse(flag_clr);

    // STOP: R4 R11
    p0 = n_stop;
    pulse(stop_set);
    for (int i = 0; i < 300 && is_master; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(n_stop == p0 + 1 && !stop_pending && !evt_flag, "R4 stop",
        {n_stop - p0, 2'b0, stop_pending, evt_flag}, 32'h10);
    chk(!scl_oe && !sda_oe && !is_master, "R4 lines released", {29'd0, scl_oe, sda_oe, is_master}, 32'd0);
    chk(!bus_busy, "R11 busy cleared by stop", {31'd0, bus_busy}, 32'd0);

    // STOP request while not master: R4
    p0 = n_stop;
    pulse(stop_set);
    @(negedge clk);
    chk(!stop_pending && !sda_oe && !scl_oe && n_stop == p0, "R4 idle stop dropped",
        {30'd0, stop_pending, sda_oe}, 32'd0);

    // START waits for a busy bus: R2 R11
    ext_sda = 1'b1;
    repeat (10) @(negedge clk);
    chk(bus_busy, "R11 external start", {31'd0, bus_busy}, 32'd1);
    pulse(start_set);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (sda_oe || scl_oe || is_master) bad++;
    end
    chk(bad == 0 && start_pending, "R2 waits while busy", bad, 0);
    ext_sda = 1'b0;
    wait_flag(300, "R2 start after free");
    chk(is_master, "R2 master after wait", {31'd0, is_master}, 32'd1);
    pulse(flag_clr);

    // arbitration loss: R9
    slv_pat = 9'b0_0000_0100;
    issue(1'b0, 8'hFF, "R9 accept");
    wait_flag(500, "R9 flag after loss");
    chk(arb_lost && !is_master, "R9 lost", {30'd0, arb_lost, is_master}, 32'd2);
    chk(rises == 9 && cap[8:1] == 8'hDF, "R9 byte completed", {rises[15:0], 8'd0, cap[8:1]}, {16'd9, 8'd0, 8'hDF});
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R9 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
    slv_pat = 9'd0;

    // disable: R1
    ctl_en = 1'b0;
    @(negedge clk);
    chk(!evt_flag && !arb_lost && !bus_busy && !is_master && !scl_oe && !sda_oe, "R1 disable clears",
        {26'd0, evt_flag, arb_lost, bus_busy, is_master, scl_oe, sda_oe}, 32'd0);
    ctl_en = 1'b1;
    @(negedge clk);
    pulse(start_set);
    wait_flag(300, "R1 restart");
    pulse(flag_clr);
    issue(1'b0, 8'h81, "R1 accept");
    repeat (12) @(negedge clk);
    ctl_en = 1'b0;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && !is_master && !start_pending, "R1 disable mid byte",
        {29'd0, scl_oe, sda_oe, is_master}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule